// File: doc/BRIEF.md
# Log-Quantized Shift-Accumulate Processing Element

This block is one multiply-and-accumulate cell for a convolution accelerator whose weights are kept as logarithmic codes. A weight code holds a sign bit and an unsigned exponent code `x`. The weight it stands for is a signed power of two with exponent `COEF_S*x + OFFS_I`. `COEF_S` and `OFFS_I` are constants fixed at elaboration. Each cycle the cell takes one signed activation and one weight code. It forms the product with a staged barrel shifter, not a multiplier. The signed product is then added to, or subtracted from, a wide accumulator.

The cell also sends its activation and weight on to the right and lower neighbours one cycle later, each with its own valid bit, so cells can be tiled into a systolic array. A synchronous clear starts a new accumulation window. The accumulator is driven on the output every cycle. A one-cycle strobe marks each cycle in which the accumulator took in an operand pair.

Top module: `logshift_pe`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `accOut`, `actOut`, `wgtOut`, `actValidOut`, `wgtValidOut` and `accValid` are all zero.
- R2: The weight code is `{sign, x}`: the sign is the MSB and `x` is the low `EXP_W` bits. When both input valids are high, `clear` is low and the sign is 0, the accumulator grows by `actIn * 2^(COEF_S*x + OFFS_I)` at the next edge.
- R3: Under the same conditions with the sign at 1, the accumulator shrinks by that same shifted product.
- R4: No weight code stands for zero. With `actIn = 1`, every code gives a magnitude of exactly `2^(COEF_S*x + OFFS_I)`, so `x = 0` gives `2^OFFS_I`.
- R5: When `actValidIn` and `wgtValidIn` are not both high and `clear` is low, the accumulator keeps its value.
- R6: `clear` with no valid operand pair sets the accumulator to zero at the next edge.
- R7: `clear` together with a valid operand pair loads the accumulator with that pair's signed product alone. This starts a new window with no idle cycle.
- R8: `actOut`, `wgtOut`, `actValidOut` and `wgtValidOut` equal `actIn`, `wgtIn`, `actValidIn` and `wgtValidIn` from one cycle earlier. This holds whatever the state of `clear`.
- R9: Activations are two's complement and are sign-extended through the shifter. `KERNEL_LEN` products of the largest magnitude (`-2^(ACT_W-1)` at the largest exponent, either sign) sum without wrapping.
- R10: With `COEF_S = 1` and `OFFS_I = 0`, the cell acts as a plain log-quantized shift cell: the exponent equals `x`.
- R11: `accValid` is high in exactly the cycles that follow an edge at which both input valids were high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous accumulator clear / window start |
| actIn | input | ACT_W | Signed activation |
| actValidIn | input | 1 | Activation valid |
| wgtIn | input | EXP_W+1 | Weight code: sign in the MSB, exponent code below it |
| wgtValidIn | input | 1 | Weight valid |
| actOut | output | ACT_W | Activation forwarded to the right neighbour |
| actValidOut | output | 1 | Forwarded activation valid |
| wgtOut | output | EXP_W+1 | Weight forwarded to the lower neighbour |
| wgtValidOut | output | 1 | Forwarded weight valid |
| accOut | output | ACC_W | Signed running accumulator |
| accValid | output | 1 | Accumulator took in an operand pair last edge |

## Verification
The hardest state to reach is an accumulator close to its width limit. Random activations and exponents almost never line up the worst-case product `KERNEL_LEN` times in a row. A directed run therefore loads the most negative activation at the largest exponent with the sign set, then repeats that pair until the window is full. Random traffic also meets clear-with-valid only now and then, so the bench forces a clear before each random window grows past the kernel length. It biases clear often enough that load, zero, add, subtract and hold all appear many times. A second instance with `COEF_S = 1` and `OFFS_I = 0` sees the same stimulus, so both exponent maps are compared against one reference model.

// File: rtl/logshift_pkg.sv
package logshift_pkg;

  // Strobes issued by the control half to the datapath each cycle.
  typedef struct packed {
    logic zero;    // clear with no operand pair
    logic load;    // clear with an operand pair: start new window
    logic accum;   // add the signed term into the running sum
    logic negate;  // weight sign set: the term is subtracted
  } peStrobes_t;

  // Largest exponent the weight code can reach.
  function automatic int maxShift(input int coefS, input int offsI, input int expW);
    return coefS * ((1 << expW) - 1) + offsI;
  endfunction

endpackage

// File: rtl/logshift_shifter.sv
// Staged barrel shifter that reaches only exponents COEF_S*x + OFFS_I.
// A fixed shift by OFFS_I is followed by one stage per code bit k,
// each shifting by COEF_S * 2^k when that bit is set.
module logshift_shifter #(
  parameter int ACT_W  = 8,
  parameter int EXP_W  = 3,
  parameter int COEF_S = 2,
  parameter int OFFS_I = 1,
  parameter int PROD_W = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [ACT_W-1:0]  actIn,
  input  logic        [EXP_W-1:0]  expCode,
  output logic signed [PROD_W-1:0] product
);

  localparam int EXT_W = PROD_W - ACT_W;

  logic signed [PROD_W-1:0] actExt;
  logic signed [PROD_W-1:0] stage [EXP_W+1];

  assign actExt   = {{EXT_W{actIn[ACT_W-1]}}, actIn};
  assign stage[0] = actExt <<< OFFS_I;

  for (genvar k = 0; k < EXP_W; k++) begin : g_stage
    localparam int STEP = COEF_S << k;
    assign stage[k+1] = expCode[k] ? (stage[k] <<< STEP) : stage[k];
  end

  assign product = stage[EXP_W];

  // R4: a nonzero activation never yields a zero product.
  assert_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (actIn != '0) |-> (product != '0));

  // R9: the sign of the activation survives the shift.
  assert_sign_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (actIn != '0) |-> (product[PROD_W-1] == actIn[ACT_W-1]));

endmodule

// File: rtl/logshift_ctrl.sv
// Control half: turns clear and the valid pair into datapath strobes,
// and registers the valids forwarded to neighbours.
module logshift_ctrl
  import logshift_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       actValidIn,
  input  logic       wgtValidIn,
  input  logic       wgtSign,
  output peStrobes_t strobes,
  output logic       actValidOut,
  output logic       wgtValidOut,
  output logic       accValid
);

  logic pairValid;

  assign pairValid = actValidIn & wgtValidIn;

  always_comb begin
    strobes        = '0;
    strobes.zero   = clear & ~pairValid;
    strobes.load   = clear &  pairValid;
    strobes.accum  = ~clear & pairValid;
    strobes.negate = pairValid & wgtSign;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      actValidOut <= 1'b0;
      wgtValidOut <= 1'b0;
      accValid    <= 1'b0;
    end else begin
      actValidOut <= actValidIn;
      wgtValidOut <= wgtValidIn;
      accValid    <= pairValid;
    end
  end

  // R8: each valid reaches the neighbour exactly one cycle later.
  assert_fwd_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (actValidOut == $past(actValidIn) && wgtValidOut == $past(wgtValidIn)));

  // R11: the result strobe follows only cycles carrying an operand pair.
  assert_acc_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (accValid == $past(actValidIn && wgtValidIn)));

endmodule

// File: rtl/logshift_datapath.sv
// Datapath half: operand forwarding registers, shifter, sign and accumulator.
module logshift_datapath
  import logshift_pkg::*;
#(
  parameter int ACT_W  = 8,
  parameter int EXP_W  = 3,
  parameter int COEF_S = 2,
  parameter int OFFS_I = 1,
  parameter int PROD_W = 23,
  parameter int ACC_W  = 30
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  peStrobes_t              strobes,
  input  logic signed [ACT_W-1:0] actIn,
  input  logic        [EXP_W:0]   wgtIn,
  output logic signed [ACT_W-1:0] actOut,
  output logic        [EXP_W:0]   wgtOut,
  output logic signed [ACC_W-1:0] accOut
);

  localparam int GROW_W = ACC_W - PROD_W;

  logic signed [PROD_W-1:0] product;
  logic signed [ACC_W-1:0]  prodExt;
  logic signed [ACC_W-1:0]  term;

  logshift_shifter #(
    .ACT_W (ACT_W),
    .EXP_W (EXP_W),
    .COEF_S(COEF_S),
    .OFFS_I(OFFS_I),
    .PROD_W(PROD_W)
  ) u_shifter (
    .clk    (clk),
    .rst_n  (rst_n),
    .actIn  (actIn),
    .expCode(wgtIn[EXP_W-1:0]),
    .product(product)
  );

  assign prodExt = {{GROW_W{product[PROD_W-1]}}, product};
  assign term    = strobes.negate ? -prodExt : prodExt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      actOut <= '0;
      wgtOut <= '0;
      accOut <= '0;
    end else begin
      actOut <= actIn;
      wgtOut <= wgtIn;
      if (strobes.zero) begin
        accOut <= '0;
      end else if (strobes.load) begin
        accOut <= term;
      end else if (strobes.accum) begin
        accOut <= accOut + term;
      end
    end
  end

  // R5: no strobe, no change.
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.zero || strobes.load || strobes.accum) |=> $stable(accOut));

  // R6: a lone clear empties the accumulator.
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.zero |=> (accOut == '0));

  // R8: operands reach the neighbours unchanged one cycle later.
  assert_fwd_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (actOut == $past(actIn) && wgtOut == $past(wgtIn)));

  // R3: a subtracted term moves the sum against the sign of the product.
  assert_negate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.load && strobes.negate && product > 0) |=> (accOut < 0));

endmodule

// File: rtl/logshift_pe.sv
// Thin top: wires the control half to the datapath half.
module logshift_pe
  import logshift_pkg::*;
#(
  parameter  int ACT_W      = 8,
  parameter  int EXP_W      = 3,
  parameter  int COEF_S     = 2,
  parameter  int OFFS_I     = 1,
  parameter  int KERNEL_LEN = 64,
  localparam int MAX_SH     = maxShift(COEF_S, OFFS_I, EXP_W),
  localparam int PROD_W     = ACT_W + MAX_SH,
  localparam int ACC_W      = PROD_W + $clog2(KERNEL_LEN) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic signed [ACT_W-1:0] actIn,
  input  logic                    actValidIn,
  input  logic        [EXP_W:0]   wgtIn,
  input  logic                    wgtValidIn,
  output logic signed [ACT_W-1:0] actOut,
  output logic                    actValidOut,
  output logic        [EXP_W:0]   wgtOut,
  output logic                    wgtValidOut,
  output logic signed [ACC_W-1:0] accOut,
  output logic                    accValid
);

  peStrobes_t strobes;

  logshift_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .actValidIn (actValidIn),
    .wgtValidIn (wgtValidIn),
    .wgtSign    (wgtIn[EXP_W]),
    .strobes    (strobes),
    .actValidOut(actValidOut),
    .wgtValidOut(wgtValidOut),
    .accValid   (accValid)
  );

  logshift_datapath #(
    .ACT_W (ACT_W),
    .EXP_W (EXP_W),
    .COEF_S(COEF_S),
    .OFFS_I(OFFS_I),
    .PROD_W(PROD_W),
    .ACC_W (ACC_W)
  ) u_datapath (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobes(strobes),
    .actIn  (actIn),
    .wgtIn  (wgtIn),
    .actOut (actOut),
    .wgtOut (wgtOut),
    .accOut (accOut)
  );

  // R6, R7: clear always wins over accumulation into the old sum.
  assert_window_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !(actValidIn && wgtValidIn)) |=> (accOut == '0));

endmodule

// File: tb/logshift_pe_bench.sv
module logshift_pe_bench;

  localparam int ACT_W  = 8;
  localparam int EXP_W  = 3;
  localparam int KLEN   = 64;
  localparam int S_A    = 2;
  localparam int I_A    = 1;
  localparam int ACC_A  = ACT_W + S_A * 7 + I_A + $clog2(KLEN) + 1;
  localparam int ACC_P  = ACT_W + 7 + $clog2(KLEN) + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic clear;
  logic signed [ACT_W-1:0] actIn;
  logic actValidIn, wgtValidIn;
  logic [EXP_W:0] wgtIn;

  logic signed [ACT_W-1:0] actOut, actOutP;
  logic actValidOut, wgtValidOut, accValid;
  logic actValidOutP, wgtValidOutP, accValidP;
  logic [EXP_W:0] wgtOut, wgtOutP;
  logic signed [ACC_A-1:0] accOut;
  logic signed [ACC_P-1:0] accOutP;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  longint expAcc, expAccP;

  always #5 clk = ~clk;

  logshift_pe #(.ACT_W(ACT_W), .EXP_W(EXP_W), .COEF_S(S_A), .OFFS_I(I_A), .KERNEL_LEN(KLEN))
    u_logshift_pe (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .actIn(actIn), .actValidIn(actValidIn), .wgtIn(wgtIn), .wgtValidIn(wgtValidIn),
      .actOut(actOut), .actValidOut(actValidOut), .wgtOut(wgtOut), .wgtValidOut(wgtValidOut),
      .accOut(accOut), .accValid(accValid));

  logshift_pe #(.ACT_W(ACT_W), .EXP_W(EXP_W), .COEF_S(1), .OFFS_I(0), .KERNEL_LEN(KLEN))
    u_logshift_pe_plain (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .actIn(actIn), .actValidIn(actValidIn), .wgtIn(wgtIn), .wgtValidIn(wgtValidIn),
      .actOut(actOutP), .actValidOut(actValidOutP), .wgtOut(wgtOutP), .wgtValidOut(wgtValidOutP),
      .accOut(accOutP), .accValid(accValidP));

  function automatic longint termOf(input logic signed [ACT_W-1:0] a,
                                    input logic [EXP_W:0] code, input int s, input int i);
    longint v;
    int e;
    e = s * int'(code[EXP_W-1:0]) + i;
    v = longint'(a) * (longint'(1) << e);
    return code[EXP_W] ? -v : v;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Apply one cycle of stimulus at a negedge, then check at the next negedge.
  task automatic step(input bit clr, input bit av, input bit wv,
                      input logic signed [ACT_W-1:0] a, input logic [EXP_W:0] w);
    bit pair;
    string tag;
    clear = clr; actValidIn = av; wgtValidIn = wv; actIn = a; wgtIn = w;
    pair = av && wv;
    if (clr && pair)      begin tag = "R7"; expAcc = termOf(a, w, S_A, I_A); expAccP = termOf(a, w, 1, 0); end
    else if (clr)         begin tag = "R6"; expAcc = 0; expAccP = 0; end
    else if (pair)        begin tag = w[EXP_W] ? "R3" : "R2";
                                expAcc += termOf(a, w, S_A, I_A); expAccP += termOf(a, w, 1, 0); end
    else                  tag = "R5";
    @(negedge clk);
    check(longint'(accOut) == expAcc, tag, longint'(accOut), expAcc);
    check(longint'(accOutP) == expAccP, "R10", longint'(accOutP), expAccP);
    check(actOut == a && wgtOut == w && actValidOut == av && wgtValidOut == wv,
          "R8", longint'({actOut, wgtOut, actValidOut, wgtValidOut}), longint'({a, w, av, wv}));
    check(accValid == pair && accValidP == pair, "R11", longint'(accValid), longint'(pair));
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int winLen;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; clear = 1'b0; actIn = '0; wgtIn = '0; actValidIn = 1'b0; wgtValidIn = 1'b0;
    expAcc = 0; expAccP = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(accOut == '0 && accOutP == '0 && actOut == '0 && wgtOut == '0 &&
          !actValidOut && !wgtValidOut && !accValid, "R1", longint'(accOut), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(accOut == '0 && !accValid && !actValidOut, "R1", longint'(accOut), 0);

    // R4: every code with activation 1 gives its exact nonzero power of two
    for (int c = 0; c < 16; c++) begin
      step(1'b1, 1'b1, 1'b1, 8'sd1, 4'(c));
      check(longint'(accOut) == termOf(8'sd1, 4'(c), S_A, I_A) && accOut != '0, "R4",
            longint'(accOut), termOf(8'sd1, 4'(c), S_A, I_A));
    end

    // R5: only one valid high, or neither, holds the sum
    step(1'b0, 1'b1, 1'b0, 8'sd100, 4'b0111);
    step(1'b0, 1'b0, 1'b1, 8'sd100, 4'b0111);
    step(1'b0, 1'b0, 1'b0, -8'sd7, 4'b1010);

    // R6: lone clear
    step(1'b1, 1'b0, 1'b0, 8'sd5, 4'b0001);

    // R9: worst-case magnitude over a full kernel, negative activation, subtract
    step(1'b1, 1'b1, 1'b1, -8'sd128, 4'b1111);
    for (int k = 1; k < KLEN; k++) step(1'b0, 1'b1, 1'b1, -8'sd128, 4'b1111);
    check(longint'(accOut) == (longint'(KLEN) << (ACT_W - 1 + S_A * 7 + I_A)), "R9",
          longint'(accOut), longint'(KLEN) << (ACT_W - 1 + S_A * 7 + I_A));
    step(1'b1, 1'b1, 1'b1, -8'sd128, 4'b0111);
    for (int k = 1; k < KLEN; k++) step(1'b0, 1'b1, 1'b1, -8'sd128, 4'b0111);
    check(longint'(accOut) == -(longint'(KLEN) << (ACT_W - 1 + S_A * 7 + I_A)), "R9",
          longint'(accOut), -(longint'(KLEN) << (ACT_W - 1 + S_A * 7 + I_A)));

    // Random traffic; windows never exceed the kernel length
    step(1'b1, 1'b0, 1'b0, '0, '0);
    winLen = 0;
    for (int n = 0; n < 4000; n++) begin
      bit clr, av, wv;
      clr = ($urandom_range(0, 15) == 0) || (winLen >= KLEN - 2);
      av  = ($urandom_range(0, 3) != 0);
      wv  = ($urandom_range(0, 3) != 0);
      step(clr, av, wv, ACT_W'($urandom), (EXP_W + 1)'($urandom));
      if (clr) winLen = (av && wv) ? 1 : 0;
      else if (av && wv) winLen++;
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule